// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block sits next to the ECC checker of a DRAM controller and records the errors that checker finds. The checker raises a one-cycle pulse for each correctable error (CE) or uncorrectable error (UE), together with the failing 4 KiB block number. A correctable error also carries its 16-bit syndrome. The bank holds two status bytes. The "first" byte flags the class of the first error that was logged. The "next" byte flags that a further error of an already-logged class arrived. The bank also holds a CE block log, a CE syndrome log and a UE block log.

Software polls the bank through a word-indexed register port. It reads the status, reads the logs of any class whose first bit is set, and then clears status bits by writing ones to them. While a class's first bit stays set, its logs are frozen. A set next bit therefore tells software that at least one error of that class was seen but not logged. The bank also drives a combinational channel hint, which is decoded from the captured CE syndrome.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous reset, both status bytes, the two block logs, the syndrome log and the channel hint all read as zero.
- R2: Register word index 0 is the first-error status and index 1 is the next-error status. In both, bit 0 flags CE and bit 1 flags UE. Index 2 is the CE block log, index 3 is the CE syndrome log (bits 15:0) and index 4 is the UE block log. Indices 5 to 7 read zero.
- R3: An error pulse whose class has its first bit clear sets that bit and loads that class's log. For a CE it also loads the syndrome. Both changes are readable after the clock edge that samples the pulse.
- R4: A block log word carries the 22-bit block number (physical address bits 33:12) in bits 27:6. Bits 31:28 and 5:0 read zero.
- R5: An error pulse whose class already has its first bit set sets that class's next bit. The block log and the syndrome log of that class keep their values.
- R6: Writing a 1 to bit 0 or bit 1 of either status register clears that bit, and writing a 0 leaves it unchanged. Writes to indices 2 to 7 change no register.
- R7: When a clear of a status bit and a new error of the same class fall on the same clock edge, the bit ends up set.
- R8: A CE pulse and a UE pulse on the same edge are each captured as though they had arrived alone.
- R9: When a class has its first bit clear and its next bit set, a new error of that class loads the log and sets the first bit, and the next bit stays set.
- R10: The channel hint is decided from the captured syndrome by the first rule that applies. If bits 15:8 are zero, the hint is 0. Otherwise, if bits 7:0 are zero, the hint is 1. Otherwise, if bits 15:12 or bits 11:8 are zero, the hint is 0. Otherwise the hint is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_valid | input | 1 | Correctable error pulse |
| ce_blk | input | PA_W-PAGE_SHIFT (22) | Failing 4 KiB block number of the CE |
| ce_syndrome | input | 16 | Syndrome of the CE |
| ue_valid | input | 1 | Uncorrectable error pulse |
| ue_blk | input | PA_W-PAGE_SHIFT (22) | Failing 4 KiB block number of the UE |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for reads and writes |
| reg_wdata | input | 2 | Write-one-to-clear mask for status bits 1:0 |
| reg_rdata | output | REG_W (32) | Combinational read data for reg_addr |
| chan_hint | output | 1 | Channel decoded from the captured syndrome |

## Verification
The bench builds the block with its default parameters: a 34-bit physical address, a 22-bit block field and 32-bit register words. The 3-bit index covers all eight register slots, so every read can sweep the whole map, including the unmapped slots.

The bench walks the syndrome through all sixteen zero/nonzero nibble patterns, which reaches every branch of the hint order. A long pseudo-random run mixes CE pulses, UE pulses and status writes against an arithmetic model. That run reaches every first/next state pair, same-edge collisions between a clear and an error, and coincident CE and UE pulses.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int SYN_W   = 16;
    localparam int STAT_W  = 2;
    localparam int NUM_CLS = 2;
    localparam int RA_W    = 3;

    // class index doubles as the status bit position
    localparam int CLS_CE = 0;
    localparam int CLS_UE = 1;

    typedef enum logic [RA_W-1:0] {
        REG_FIRST  = 3'd0,
        REG_NEXT   = 3'd1,
        REG_CE_LOG = 3'd2,
        REG_CE_SYN = 3'd3,
        REG_UE_LOG = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic ue;
        logic ce;
    } stat_t;

    // ordered decode of the syndrome into a channel number
    function automatic logic chan_of_syndrome(input logic [SYN_W-1:0] s);
        logic ch;
        if (s[15:8] == 8'h00)
            ch = 1'b0;
        else if (s[7:0] == 8'h00)
            ch = 1'b1;
        else if (s[15:12] == 4'h0 || s[11:8] == 4'h0)
            ch = 1'b0;
        else
            ch = 1'b1;
        return ch;
    endfunction

endpackage

// File: rtl/ecc_cls_track.sv
module ecc_cls_track #(
    parameter int BLK_W     = 22,
    parameter int LOG_W     = 32,
    parameter int FIELD_LSB = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [BLK_W-1:0] blk,
    input  logic             clr_first,
    input  logic             clr_next,
    output logic             first_q,
    output logic             next_q,
    output logic [LOG_W-1:0] log_q,
    output logic             load_o
);

    localparam int FIELD_MSB = FIELD_LSB + BLK_W - 1;

    logic [LOG_W-1:0] log_fmt;
    logic             repeat_evt;

    always_comb begin
        log_fmt = '0;
        log_fmt[FIELD_MSB:FIELD_LSB] = blk;
    end

    assign load_o     = evt & ~first_q;
    assign repeat_evt = evt &  first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            next_q  <= 1'b0;
            log_q   <= '0;
        end else begin
            if (evt)
                first_q <= 1'b1;
            else if (clr_first)
                first_q <= 1'b0;

            if (repeat_evt)
                next_q <= 1'b1;
            else if (clr_next)
                next_q <= 1'b0;

            if (load_o)
                log_q <= log_fmt;
        end
    end

    // R3: a fresh error latches the first bit
    p_fresh_sets_first_r3: assert property (@(posedge clk) disable iff (rst)
        (evt && !first_q) |=> first_q);

    // R5: a repeat error marks overflow and freezes the log
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (evt && first_q) |=> (next_q && $stable(log_q)));

    // R7: an error beats a same-edge clear
    p_err_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (evt && clr_first) |=> first_q);

    // R6: a clear with no error drops the bit
    p_w1c_first_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_first && !evt) |=> !first_q);

    // R6: next bit clears when no repeat error arrives
    p_w1c_next_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_next && !(evt && first_q)) |=> !next_q);

endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
    import ecc_cap_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic [RA_W-1:0]  addr,
    input  stat_t            first_st,
    input  stat_t            next_st,
    input  logic [REG_W-1:0] ce_log,
    input  logic [SYN_W-1:0] ce_syn,
    input  logic [REG_W-1:0] ue_log,
    output logic [REG_W-1:0] rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_comb begin
        rdata = '0;
        case (sel)
            REG_FIRST:  rdata = REG_W'(first_st);
            REG_NEXT:   rdata = REG_W'(next_st);
            REG_CE_LOG: rdata = ce_log;
            REG_CE_SYN: rdata = REG_W'(ce_syn);
            REG_UE_LOG: rdata = ue_log;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int PA_W       = 34,
    parameter int PAGE_SHIFT = 12,
    parameter int REG_W      = 32,
    parameter int FIELD_LSB  = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ce_valid,
    input  logic [PA_W-PAGE_SHIFT-1:0] ce_blk,
    input  logic [SYN_W-1:0]           ce_syndrome,
    input  logic                       ue_valid,
    input  logic [PA_W-PAGE_SHIFT-1:0] ue_blk,
    input  logic                       reg_wr,
    input  logic [RA_W-1:0]            reg_addr,
    input  logic [STAT_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       chan_hint
);

    localparam int BLK_W = PA_W - PAGE_SHIFT;

    logic [NUM_CLS-1:0] evt_v, clr_f, clr_n, first_v, next_v, load_v;
    logic [BLK_W-1:0]   blk_v [NUM_CLS];
    logic [REG_W-1:0]   log_v [NUM_CLS];
    logic [SYN_W-1:0]   syn_q;
    logic               wr_first, wr_next;
    stat_t              first_st, next_st;

    assign evt_v[CLS_CE] = ce_valid;
    assign evt_v[CLS_UE] = ue_valid;
    assign blk_v[CLS_CE] = ce_blk;
    assign blk_v[CLS_UE] = ue_blk;

    assign wr_first = reg_wr && (reg_sel_e'(reg_addr) == REG_FIRST);
    assign wr_next  = reg_wr && (reg_sel_e'(reg_addr) == REG_NEXT);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign clr_f[c] = wr_first & reg_wdata[c];
        assign clr_n[c] = wr_next  & reg_wdata[c];

        ecc_cls_track #(
            .BLK_W     (BLK_W),
            .LOG_W     (REG_W),
            .FIELD_LSB (FIELD_LSB)
        ) u_trk (
            .clk       (clk),
            .rst       (rst),
            .evt       (evt_v[c]),
            .blk       (blk_v[c]),
            .clr_first (clr_f[c]),
            .clr_next  (clr_n[c]),
            .first_q   (first_v[c]),
            .next_q    (next_v[c]),
            .log_q     (log_v[c]),
            .load_o    (load_v[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            syn_q <= '0;
        else if (load_v[CLS_CE])
            syn_q <= ce_syndrome;
    end

    assign first_st = stat_t'(first_v);
    assign next_st  = stat_t'(next_v);

    ecc_reg_read #(.REG_W(REG_W)) u_rd (
        .addr     (reg_addr),
        .first_st (first_st),
        .next_st  (next_st),
        .ce_log   (log_v[CLS_CE]),
        .ce_syn   (syn_q),
        .ue_log   (log_v[CLS_UE]),
        .rdata    (reg_rdata)
    );

    assign chan_hint = chan_of_syndrome(syn_q);

    // R5: the syndrome log stays frozen while the CE first bit is set
    p_syn_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && first_v[CLS_CE]) |=> $stable(syn_q));

    // R8: coincident CE and UE both end with their first bits set
    p_dual_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (ce_valid && ue_valid) |=> (first_v == 2'b11));

    // R6: a write to a log slot leaves the logs untouched
    p_log_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !ce_valid && !ue_valid) |=> ($stable(syn_q) && $stable(log_v[CLS_CE]) && $stable(log_v[CLS_UE])));

endmodule

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/100ps
module ecc_err_capture_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_valid, ue_valid, reg_wr;
    logic [21:0] ce_blk, ue_blk;
    logic [15:0] ce_syndrome;
    logic [2:0]  reg_addr;
    logic [1:0]  reg_wdata;
    logic [31:0] reg_rdata;
    logic        chan_hint;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    // model state derived from the requirements
    logic [1:0]  m_first, m_next;
    logic [31:0] m_celog, m_uelog;
    logic [15:0] m_syn;
    logic [31:0] lfsr = 32'hACE1_1234;

    always #5 clk = ~clk;

    ecc_err_capture u_ecc_err_capture (
        .clk(clk), .rst(rst), .ce_valid(ce_valid), .ce_blk(ce_blk),
        .ce_syndrome(ce_syndrome), .ue_valid(ue_valid), .ue_blk(ue_blk),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chan_hint(chan_hint)
    );

    function automatic logic [31:0] fmt(input logic [21:0] b);
        return {10'd0, b} * 32'd64;
    endfunction

    function automatic logic exp_hint(input logic [15:0] s);
        if ((s / 256) == 0) return 1'b0;
        if ((s % 256) == 0) return 1'b1;
        if ((s / 4096) == 0 || ((s / 256) % 16) == 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        rd_chk({tag, " first"}, 3'd0, {30'd0, m_first});
        rd_chk({tag, " next"},  3'd1, {30'd0, m_next});
        rd_chk({tag, " celog"}, 3'd2, m_celog);
        rd_chk({tag, " syn"},   3'd3, {16'd0, m_syn});
        rd_chk({tag, " uelog"}, 3'd4, m_uelog);
        chk({tag, " R10 hint"}, {31'd0, chan_hint}, {31'd0, exp_hint(m_syn)});
    endtask

    task automatic step(input logic ce, input logic [21:0] cb, input logic [15:0] cs,
                        input logic ue, input logic [21:0] ub,
                        input logic wr, input logic [2:0] wa, input logic [1:0] wd);
        logic [1:0] old_first;
        logic [1:0] ev;
        ce_valid = ce; ce_blk = cb; ce_syndrome = cs;
        ue_valid = ue; ue_blk = ub;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        old_first = m_first;
        ev = {ue, ce};
        for (int c = 0; c < 2; c++) begin
            if (ev[c]) begin
                if (old_first[c]) m_next[c] = 1'b1;
                else begin
                    m_first[c] = 1'b1;
                    if (c == 0) begin m_celog = fmt(cb); m_syn = cs; end
                    else m_uelog = fmt(ub);
                end
            end else if (wr && wa == 3'd0 && wd[c]) m_first[c] = 1'b0;
            if (!(ev[c] && old_first[c]) && wr && wa == 3'd1 && wd[c]) m_next[c] = 1'b0;
        end
        @(negedge clk);
        ce_valid = 0; ue_valid = 0; reg_wr = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; ce_valid = 0; ue_valid = 0; reg_wr = 0;
        ce_blk = 0; ue_blk = 0; ce_syndrome = 0; reg_addr = 0; reg_wdata = 0;
        m_first = 0; m_next = 0; m_celog = 0; m_uelog = 0; m_syn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1 reset");
        for (int a = 5; a < 8; a++) rd_chk("R2 unmapped", 3'(a), 32'd0);

        // R3 R4: first CE loads log and syndrome
        step(1, 22'h3FFFFF, 16'hA5C3, 0, 0, 0, 0, 0);
        check_all("R3 R4 first CE");
        rd_chk("R4 log all ones", 3'd2, 32'h0FFF_FFC0);
        // R5: repeat CE freezes log
        step(1, 22'h000123, 16'h0011, 0, 0, 0, 0, 0);
        check_all("R5 repeat CE");
        // R6: zero write no effect; write to log slot ignored
        step(0, 0, 0, 0, 0, 1, 3'd0, 2'b00);
        check_all("R6 zero write");
        step(0, 0, 0, 0, 0, 1, 3'd2, 2'b11);
        check_all("R6 log slot write");
        step(0, 0, 0, 0, 0, 1, 3'd0, 2'b01);
        check_all("R6 clear first");
        // R9: first clear, next set, new CE relogs
        step(1, 22'h0ABCDE, 16'h1200, 0, 0, 0, 0, 0);
        check_all("R9 relog");
        // R7: clear and CE on the same edge
        step(1, 22'h000777, 16'h0F0F, 0, 0, 1, 3'd0, 2'b01);
        check_all("R7 collision");
        // R8: coincident CE and UE from clean state
        step(0, 0, 0, 0, 0, 1, 3'd0, 2'b11);
        step(0, 0, 0, 0, 0, 1, 3'd1, 2'b11);
        check_all("R6 clear all");
        step(1, 22'h155555, 16'hFFFF, 1, 22'h2AAAAA, 0, 0, 0);
        check_all("R8 dual");

        // R10: all nibble zero/nonzero patterns
        for (int p = 0; p < 16; p++) begin
            for (int v = 0; v < 2; v++) begin
                logic [15:0] s;
                s = 0;
                for (int n = 0; n < 4; n++)
                    if (p[n]) s = s | (16'((v == 0) ? 1 : 9 + n) << (4 * n));
                step(0, 0, 0, 0, 0, 1, 3'd0, 2'b11);
                step(1, 22'(p * 2 + v), s, 0, 0, 0, 0, 0);
                check_all("R10 sweep");
            end
        end

        // random mix for R3 R5 R6 R7 R8 R9
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1, r2;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r1 = lfsr * 32'd1664525 + 32'd1013904223;
            r2 = r1 * 32'd22695477 + 32'd1;
            step(r1[0] & r1[1], r1[31:10], r2[15:0], r1[2] & r1[3], r2[31:10],
                 r1[4], 3'(r1[7:5] % 5), r1[9:8]);
            check_all("R3 R5 R7 R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule